// File: doc/BRIEF.md
# Supply Undervoltage Monitor Controller

This block is the digital half of a supply-voltage watchdog in a microcontroller. Two comparators, outside the block, report whether the supply has dropped below a falling trip level and whether it has climbed above a separate, higher rising trip level. The block synchronizes both indications. It keeps a status flag that software can read on a simple 8-bit read bus, and it raises a system reset request together with an active-low reset pin drive.

Static configuration selects the mode of operation. One bit powers the monitor down. A second bit turns it into a polled flag with no reset. A third bit keeps the monitor alive in stop mode. A fourth bit picks the 5 V or 3 V threshold pair, and that choice only reaches the comparators. Because the reset is set by the falling comparator and cleared only by the rising one, the release threshold has hysteresis.

Top module: `supply_monitor_ctrl`

## Requirements
- R1: While `cfgPowerDown` is 1 the monitor is off. The status flag reads 0 and `resetReq` stays 0, whatever the comparator inputs do.
- R2: While `cfgResetDisable` is 1 and the monitor is on, a low supply only sets the status flag and never raises `resetReq`.
- R3: With `cfgPowerDown`, `cfgResetDisable` and stop gating all inactive, a synchronized `belowFall` of 1 sets `resetReq` to 1 on the next clock edge.
- R4: Once set, `resetReq` stays 1 until the synchronized `aboveRise` is 1, even after `belowFall` returns to 0. It also clears when the monitor is switched off.
- R5: `resetPinN` is 0 in exactly the cycles where `resetReq` is 1.
- R6: The status flag is bit 7 of the status register. It reads 1 while the monitor is on and the synchronized `belowFall` is 1, and 0 otherwise. A change on `belowFall` driven between edges appears in the flag after the third following rising clock edge: two synchronizer stages plus the flag register.
- R7: `busRdata` is combinational. It carries the status register when `busRead` is 1 and `busAddr` equals `STATUS_ADDR`, and it is 0x00 otherwise. Bits 6..0 of the register always read 0, and the register reads 0x00 after reset.
- R8: While `stopMode` is 1 and `cfgStopKeep` is 0 the monitor is gated off, as in R1. With `cfgStopKeep` 1 it keeps running in stop mode.
- R9: `rangeSel` equals `cfgRange5v` in every cycle (1 selects the 5 V pair) and has no effect on the flag or the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| belowFall | input | 1 | Comparator: supply below falling trip level |
| aboveRise | input | 1 | Comparator: supply above rising trip level |
| cfgPowerDown | input | 1 | 1 switches the monitor off |
| cfgResetDisable | input | 1 | 1 selects polled mode (no reset) |
| cfgStopKeep | input | 1 | 1 keeps the monitor running in stop mode |
| cfgRange5v | input | 1 | Threshold pair select, 1 = 5 V |
| stopMode | input | 1 | Chip is in stop mode |
| busRead | input | 1 | Read strobe |
| busAddr | input | 8 | Read address |
| busRdata | output | 8 | Read data |
| rangeSel | output | 1 | Threshold select to the comparators |
| resetReq | output | 1 | Reset request to the system sequencer |
| resetPinN | output | 1 | Active-low reset pin drive |

## Verification
The bench drives the supply down below the falling level and then back up only as far as the band between the two levels. A design without hysteresis would drop the reset at that point, when it should keep holding it. The bench then raises the supply past the rising level, which must release the reset. It also covers polled mode, power-down, and stop mode both with and without keep-alive. A design that ignored any of these settings would request a reset, or show a nonzero flag, where none may appear. The reference model is checked on every cycle, so an error in the three-edge flag latency or a wrong read address decode would also show up.

// File: rtl/supply_monitor_pkg.sv
package supply_monitor_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic monEnable;  // monitor currently active
    logic tripHeld;   // reset latched by falling trip
  } monCtl_t;
endpackage

// File: rtl/supply_monitor_datapath.sv
module supply_monitor_datapath
  import supply_monitor_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowIn,
  input  logic              aboveIn,
  input  monCtl_t           ctl,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              belowSync,
  output logic              aboveSync,
  output logic [DATA_W-1:0] busRdata
);
  localparam int CHANNELS = 2;
  localparam int PAD_W = DATA_W - 1;

  logic [CHANNELS-1:0] rawIn;
  logic [CHANNELS-1:0] syncOut;
  logic statusFlag;

  assign rawIn = {aboveIn, belowIn};

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[ch]};
    end
    assign syncOut[ch] = chain[SYNC_STAGES-1];
  end

  assign belowSync = syncOut[0];
  assign aboveSync = syncOut[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusFlag <= 1'b0;
    else       statusFlag <= ctl.monEnable & belowSync;
  end

  always_comb begin
    if (busRead && busAddr == STATUS_ADDR) busRdata = {statusFlag, {PAD_W{1'b0}}};
    else                                   busRdata = '0;
  end
endmodule

// File: rtl/supply_monitor_fsm.sv
module supply_monitor_fsm
  import supply_monitor_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    belowSync,
  input  logic    aboveSync,
  input  logic    cfgPowerDown,
  input  logic    cfgResetDisable,
  input  logic    cfgStopKeep,
  input  logic    stopMode,
  output monCtl_t ctl
);
  typedef enum logic {ARMED, TRIPPED} tripState_t;
  tripState_t state, stateNext;
  logic active;

  assign active = !cfgPowerDown && !(stopMode && !cfgStopKeep);

  always_comb begin
    stateNext = state;
    if (!active) stateNext = ARMED;
    else begin
      case (state)
        ARMED:   if (belowSync && !cfgResetDisable) stateNext = TRIPPED;
        TRIPPED: if (aboveSync) stateNext = ARMED;
        default: stateNext = ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ARMED;
    else       state <= stateNext;
  end

  assign ctl.monEnable = active;
  assign ctl.tripHeld  = (state == TRIPPED);
endmodule

// File: rtl/supply_monitor_ctrl.sv
module supply_monitor_ctrl
  import supply_monitor_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowFall,
  input  logic              aboveRise,
  input  logic              cfgPowerDown,
  input  logic              cfgResetDisable,
  input  logic              cfgStopKeep,
  input  logic              cfgRange5v,
  input  logic              stopMode,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busRdata,
  output logic              rangeSel,
  output logic              resetReq,
  output logic              resetPinN
);
  monCtl_t ctl;
  logic belowSync, aboveSync;

  supply_monitor_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .belowIn(belowFall), .aboveIn(aboveRise),
    .ctl(ctl), .busRead(busRead), .busAddr(busAddr),
    .belowSync(belowSync), .aboveSync(aboveSync), .busRdata(busRdata)
  );

  supply_monitor_fsm i_fsm (
    .clk(clk), .rstN(rstN), .belowSync(belowSync), .aboveSync(aboveSync),
    .cfgPowerDown(cfgPowerDown), .cfgResetDisable(cfgResetDisable),
    .cfgStopKeep(cfgStopKeep), .stopMode(stopMode), .ctl(ctl)
  );

  assign rangeSel  = cfgRange5v;
  assign resetReq  = ctl.tripHeld;
  assign resetPinN = !ctl.tripHeld;
endmodule

// File: rtl/supply_monitor_checker.sv
module supply_monitor_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              resetReq,
  input logic              resetPinN,
  input logic [DATA_W-1:0] busRdata,
  input logic              cfgPowerDown,
  input logic              cfgResetDisable,
  input logic              cfgStopKeep,
  input logic              stopMode,
  input logic              aboveSync
);
  assert_powerdown_no_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgPowerDown |=> !resetReq);

  assert_polled_no_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgResetDisable && !resetReq) |=> !resetReq);

  assert_reset_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && !aboveSync && !cfgPowerDown && !(stopMode && !cfgStopKeep)) |=> resetReq);

  assert_pin_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    resetPinN != resetReq);

  assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-2:0] == '0);

  assert_stop_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !cfgStopKeep) |=> !resetReq);
endmodule

bind supply_monitor_ctrl supply_monitor_checker #(.DATA_W(DATA_W)) i_checker (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .resetPinN(resetPinN),
  .busRdata(busRdata), .cfgPowerDown(cfgPowerDown),
  .cfgResetDisable(cfgResetDisable), .cfgStopKeep(cfgStopKeep),
  .stopMode(stopMode), .aboveSync(aboveSync)
);

// File: tb/test_supply_monitor_ctrl.sv
`timescale 1ns/1ps
module test_supply_monitor_ctrl;
  localparam logic [7:0] ADDR = 8'h0C;
  logic clk = 0, rstN = 0;
  logic belowFall = 0, aboveRise = 0, cfgPowerDown = 0, cfgResetDisable = 0;
  logic cfgStopKeep = 0, cfgRange5v = 0, stopMode = 0, busRead = 1;
  logic [7:0] busAddr = ADDR;
  logic [7:0] busRdata;
  logic rangeSel, resetReq, resetPinN;
  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit mB1, mB2, mA1, mA2, mFlag, mTrip;

  always #4 clk = ~clk;

  supply_monitor_ctrl #(.STATUS_ADDR(ADDR)) i_supply_monitor_ctrl (
    .clk(clk), .rstN(rstN), .belowFall(belowFall), .aboveRise(aboveRise),
    .cfgPowerDown(cfgPowerDown), .cfgResetDisable(cfgResetDisable),
    .cfgStopKeep(cfgStopKeep), .cfgRange5v(cfgRange5v), .stopMode(stopMode),
    .busRead(busRead), .busAddr(busAddr), .busRdata(busRdata),
    .rangeSel(rangeSel), .resetReq(resetReq), .resetPinN(resetPinN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update at each edge, then compare away from the edge
  always @(posedge clk) begin
    bit act;
    logic [7:0] expRd;
    act = !cfgPowerDown && !(stopMode && !cfgStopKeep);
    if (!rstN) begin
      {mB1, mB2, mA1, mA2, mFlag, mTrip} = '0;
    end else begin
      mFlag = act && mB2;
      if (!act) mTrip = 0;
      else if (mTrip) mTrip = !mA2;
      else mTrip = mB2 && !cfgResetDisable;
      mB2 = mB1; mB1 = belowFall;
      mA2 = mA1; mA1 = aboveRise;
    end
    #2;
    expRd = (busRead && busAddr == ADDR) ? {mFlag, 7'b0} : 8'h00;
    check(busRdata == expRd, "R6/R7 status read", busRdata, expRd);
    check(resetReq == mTrip, "R3/R4 reset request", resetReq, mTrip);
    check(resetPinN == !mTrip, "R5 reset pin", resetPinN, !mTrip);
    check(rangeSel == cfgRange5v, "R9 range select", rangeSel, cfgRange5v);
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_cycles(3);
    check(busRdata == 8'h00 && resetReq == 0 && resetPinN == 1, "R7 reset state", busRdata, 0);
    rstN = 1;
    wait_cycles(3);
    // R3 forced reset, R4 hysteresis
    belowFall = 1; wait_cycles(5);
    check(resetReq == 1, "R3 forced reset asserted", resetReq, 1);
    check(busRdata == 8'h80, "R6 flag set", busRdata, 8'h80);
    belowFall = 0; wait_cycles(6);
    check(resetReq == 1, "R4 held between levels", resetReq, 1);
    check(busRdata == 8'h00, "R6 flag cleared", busRdata, 0);
    aboveRise = 1; wait_cycles(5);
    check(resetReq == 0, "R4 released above rising", resetReq, 0);
    aboveRise = 0; wait_cycles(3);
    // R2 polled mode
    cfgResetDisable = 1; belowFall = 1; wait_cycles(6);
    check(resetReq == 0, "R2 polled no reset", resetReq, 0);
    check(busRdata == 8'h80, "R2 polled flag", busRdata, 8'h80);
    // R7 address mismatch and no read strobe
    busAddr = 8'h0D; wait_cycles(1);
    check(busRdata == 8'h00, "R7 wrong address", busRdata, 0);
    busAddr = ADDR; busRead = 0; wait_cycles(1);
    check(busRdata == 8'h00, "R7 no read strobe", busRdata, 0);
    busRead = 1; belowFall = 0; cfgResetDisable = 0; wait_cycles(4);
    // R1 power-down
    cfgPowerDown = 1; belowFall = 1; wait_cycles(6);
    check(busRdata == 8'h00, "R1 power-down flag", busRdata, 0);
    check(resetReq == 0, "R1 power-down no reset", resetReq, 0);
    cfgPowerDown = 0; wait_cycles(2);
    check(resetReq == 1, "R3 reset after re-enable", resetReq, 1);
    aboveRise = 1; belowFall = 0; wait_cycles(5);
    aboveRise = 0; wait_cycles(3);
    // R8 stop gating
    stopMode = 1; cfgStopKeep = 0; belowFall = 1; wait_cycles(6);
    check(resetReq == 0 && busRdata == 8'h00, "R8 stop gated", resetReq, 0);
    cfgStopKeep = 1; wait_cycles(3);
    check(resetReq == 1, "R8 stop keep-alive", resetReq, 1);
    check(busRdata == 8'h80, "R8 stop keep flag", busRdata, 8'h80);
    cfgStopKeep = 0; wait_cycles(2);
    check(resetReq == 0, "R8 gating releases", resetReq, 0);
    stopMode = 0; belowFall = 0; aboveRise = 1; wait_cycles(5);
    aboveRise = 0;
    // R9 range select
    cfgRange5v = 1; wait_cycles(2);
    check(rangeSel == 1 && resetReq == 0, "R9 range 5V", rangeSel, 1);
    cfgRange5v = 0; wait_cycles(2);
    check(rangeSel == 0, "R9 range 3V", rangeSel, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule